// File: doc/BRIEF.md
# Multi-ring free-descriptor threshold monitor

This block watches a set of circular receive descriptor rings and raises one back-pressure request whenever any enabled ring is running short of free descriptors. For each ring it holds a base address, a ring length, a threshold, an active flag, a hardware consume index and a software freed index. A write-back strobe moves the consume index forward by one descriptor. Software reports a released descriptor by writing that descriptor's byte address. The block turns the address into an index using the programmed base.

The free count of a ring is the forward distance from the consume index to the freed index, taken modulo the ring length. There is one exception. A freshly based ring has no last-freed descriptor yet, so its count is the whole ring length. The descriptor that the consume index points at is counted as though it were free. The count is therefore one higher than what is really available, so software should free at least two descriptors per update. Lengths, thresholds and active flags are copied into working registers only while the receiver is disabled, so they hold still while it runs. Base writes act at once.

Top module: `rx_freebd_monitor`

## Requirements
- R1: After reset, `backpressure` is 0, `ring_below` is all zeros and every `ring_free` field is 0.
- R2: A base write (`cfg_field` = 0) to a ring sets its consume and freed indices to descriptor 0, at any time. From then on the ring reports its full working length as its free count, until its first write-back or accepted freed write.
- R3: While `rx_en` is 1, each `wb_strobe[i]` pulse advances ring i's consume index by one. The index wraps from length-1 to 0, and the free count drops by one (modulo the length).
- R4: A freed write stores index (`free_addr` - base) / DESC_BYTES, with DESC_BYTES = 8 by default. The free count becomes (freed - consume) mod length. A write whose address lies below the base, or whose index is not below the length, is ignored.
- R5: Once a ring has left its initial state, equal consume and freed indices give a free count of 0.
- R6: A ring is below threshold when its free count is strictly less than its working threshold (`cfg_field` = 2). A count equal to the threshold is not below.
- R7: A ring whose working active flag (`cfg_field` = 3, bit 0) is 0 never shows in `ring_below` or `backpressure`.
- R8: `backpressure` is 1 while any active ring is below threshold. It clears only when every active ring meets its threshold.
- R9: While `rx_en` is 0, `backpressure` and `ring_below` are 0 and write-back strobes are ignored.
- R10: Length (`cfg_field` = 1), threshold and active values written while `rx_en` is 1 have no effect until the receiver has been disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ring | input | RING_W | Ring selected by the configuration write |
| cfg_field | input | 2 | 0 base, 1 length, 2 threshold, 3 active |
| cfg_data | input | ADDR_W | Configuration write data |
| free_we | input | 1 | Freed-descriptor write strobe |
| free_ring | input | RING_W | Ring of the freed descriptor |
| free_addr | input | ADDR_W | Byte address of the freed descriptor |
| wb_strobe | input | NUM_RINGS | One pulse per descriptor written back, per ring |
| backpressure | output | 1 | Registered combined back-pressure request |
| ring_below | output | NUM_RINGS | Registered per-ring below-threshold flags |
| ring_free | output | NUM_RINGS*CNT_W | Registered per-ring free counts, ring 0 in the low field |

## Verification
The hardest condition to reach is a ring whose consume index has wrapped all the way back onto its freed index. There the count must read 0 and not the full length of the initial state. The stimulus gets there by driving a whole ring's worth of write-backs into an inactive ring, then into an active one after repositioning its freed index. The bench also makes two rings fall below threshold at once. It then releases them one at a time, so the request is seen to hold until the last one recovers. Threshold rewrites are issued while the receiver runs and again across a disable and enable cycle, to show the working copy stays frozen.

// File: rtl/rxbp_pkg.sv
package rxbp_pkg;
  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_LEN  = 2'd1,
    FLD_THR  = 2'd2,
    FLD_ACT  = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/rxbp_cfg_regs.sv
module rxbp_cfg_regs
  import rxbp_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 7,
  parameter int RING_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rx_en,
  input  logic                          cfg_we,
  input  logic [RING_W-1:0]             cfg_ring,
  input  logic [1:0]                    cfg_field,
  input  logic [ADDR_W-1:0]             cfg_data,
  output logic [NUM_RINGS*ADDR_W-1:0]   base_flat,
  output logic [NUM_RINGS-1:0]          base_wr,
  output logic [NUM_RINGS*CNT_W-1:0]    len_w_flat,
  output logic [NUM_RINGS*CNT_W-1:0]    thr_w_flat,
  output logic [NUM_RINGS-1:0]          act_w
);
  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
    logic              sel;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  len_p, thr_p, len_s, thr_s;
    logic              act_p, act_s;

    assign sel = cfg_we && (cfg_ring == RING_W'(i));
    assign base_wr[i] = sel && (cfg_field == FLD_BASE);

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        len_p  <= '0;
        thr_p  <= '0;
        act_p  <= 1'b0;
      end else if (sel) begin
        case (cfg_field)
          FLD_BASE: base_q <= cfg_data;
          FLD_LEN:  len_p  <= cfg_data[CNT_W-1:0];
          FLD_THR:  thr_p  <= cfg_data[CNT_W-1:0];
          default:  act_p  <= cfg_data[0];
        endcase
      end
    end

    // working copies follow the programmed values only while disabled
    always_ff @(posedge clk) begin
      if (rst) begin
        len_s <= '0;
        thr_s <= '0;
        act_s <= 1'b0;
      end else if (!rx_en) begin
        len_s <= len_p;
        thr_s <= thr_p;
        act_s <= act_p;
      end
    end

    assign base_flat[i*ADDR_W +: ADDR_W] = base_q;
    assign len_w_flat[i*CNT_W +: CNT_W]  = len_s;
    assign thr_w_flat[i*CNT_W +: CNT_W]  = thr_s;
    assign act_w[i]                      = act_s;
  end
endmodule

// File: rtl/rxbp_ring_ptr.sv
module rxbp_ring_ptr #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 6,
  parameter int CNT_W      = 7,
  parameter int DESC_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  len,
  input  logic              base_wr,
  input  logic              free_we,
  input  logic [ADDR_W-1:0] free_addr,
  input  logic              wb,
  output logic [CNT_W-1:0]  free_cnt
);
  logic [IDX_W-1:0]  hw_idx, fr_idx;
  logic              empty;
  logic [ADDR_W-1:0] offset, idx_wide;
  logic              in_range;
  logic [CNT_W-1:0]  hw_inc, hw_x, fr_x;
  logic [IDX_W-1:0]  hw_next;

  assign offset   = free_addr - base;
  assign idx_wide = offset >> DESC_SHIFT;
  assign in_range = idx_wide < ADDR_W'(len);

  assign hw_x    = {1'b0, hw_idx};
  assign fr_x    = {1'b0, fr_idx};
  assign hw_inc  = hw_x + CNT_W'(1);
  assign hw_next = (hw_inc >= len) ? '0 : hw_inc[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || base_wr) begin
      hw_idx <= '0;
      fr_idx <= '0;
      empty  <= 1'b1;
    end else begin
      if (wb && rx_en) begin
        hw_idx <= hw_next;
        empty  <= 1'b0;
      end
      if (free_we && in_range) begin
        fr_idx <= idx_wide[IDX_W-1:0];
        empty  <= 1'b0;
      end
    end
  end

  always_comb begin
    if (empty)             free_cnt = len;
    else if (fr_x >= hw_x) free_cnt = fr_x - hw_x;
    else                   free_cnt = fr_x + len - hw_x;
  end
endmodule

// File: rtl/rxbp_combine.sv
module rxbp_combine #(
  parameter int NUM_RINGS = 4,
  parameter int CNT_W     = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_en,
  input  logic [NUM_RINGS*CNT_W-1:0] free_flat,
  input  logic [NUM_RINGS*CNT_W-1:0] thr_flat,
  input  logic [NUM_RINGS-1:0]       act,
  output logic                       backpressure,
  output logic [NUM_RINGS-1:0]       ring_below,
  output logic [NUM_RINGS*CNT_W-1:0] ring_free
);
  logic [NUM_RINGS-1:0] below_c;

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_cmp
    assign below_c[i] = rx_en && act[i] &&
                        (free_flat[i*CNT_W +: CNT_W] < thr_flat[i*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      backpressure <= 1'b0;
      ring_below   <= '0;
      ring_free    <= '0;
    end else begin
      backpressure <= |below_c;
      ring_below   <= below_c;
      ring_free    <= free_flat;
    end
  end
endmodule

// File: rtl/rx_freebd_monitor.sv
module rx_freebd_monitor #(
  parameter int NUM_RINGS  = 4,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 6,
  parameter int DESC_SHIFT = 3,
  localparam int CNT_W     = IDX_W + 1,
  localparam int RING_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_en,
  input  logic                       cfg_we,
  input  logic [RING_W-1:0]          cfg_ring,
  input  logic [1:0]                 cfg_field,
  input  logic [ADDR_W-1:0]          cfg_data,
  input  logic                       free_we,
  input  logic [RING_W-1:0]          free_ring,
  input  logic [ADDR_W-1:0]          free_addr,
  input  logic [NUM_RINGS-1:0]       wb_strobe,
  output logic                       backpressure,
  output logic [NUM_RINGS-1:0]       ring_below,
  output logic [NUM_RINGS*CNT_W-1:0] ring_free
);
  logic [NUM_RINGS*ADDR_W-1:0] base_flat;
  logic [NUM_RINGS-1:0]        base_wr;
  logic [NUM_RINGS*CNT_W-1:0]  len_w_flat, thr_w_flat, free_flat;
  logic [NUM_RINGS-1:0]        act_w;

  rxbp_cfg_regs #(
    .NUM_RINGS(NUM_RINGS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RING_W(RING_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .rx_en(rx_en),
    .cfg_we(cfg_we), .cfg_ring(cfg_ring), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .base_flat(base_flat), .base_wr(base_wr),
    .len_w_flat(len_w_flat), .thr_w_flat(thr_w_flat), .act_w(act_w)
  );

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ptr
    rxbp_ring_ptr #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .DESC_SHIFT(DESC_SHIFT)
    ) u_ptr (
      .clk(clk), .rst(rst), .rx_en(rx_en),
      .base(base_flat[i*ADDR_W +: ADDR_W]),
      .len(len_w_flat[i*CNT_W +: CNT_W]),
      .base_wr(base_wr[i]),
      .free_we(free_we && (free_ring == RING_W'(i))),
      .free_addr(free_addr),
      .wb(wb_strobe[i]),
      .free_cnt(free_flat[i*CNT_W +: CNT_W])
    );
  end

  rxbp_combine #(.NUM_RINGS(NUM_RINGS), .CNT_W(CNT_W)) u_comb (
    .clk(clk), .rst(rst), .rx_en(rx_en),
    .free_flat(free_flat), .thr_flat(thr_w_flat), .act(act_w),
    .backpressure(backpressure), .ring_below(ring_below), .ring_free(ring_free)
  );
endmodule

// File: rtl/rxbp_checker.sv
module rxbp_checker #(
  parameter int NUM_RINGS = 4,
  parameter int CNT_W     = 7
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rx_en,
  input logic                       backpressure,
  input logic [NUM_RINGS-1:0]       ring_below,
  input logic [NUM_RINGS*CNT_W-1:0] ring_free,
  input logic [NUM_RINGS*CNT_W-1:0] thr_w_flat,
  input logic [NUM_RINGS-1:0]       act_w
);
  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_en) |-> (!backpressure && ring_below == '0));

  a_r8_request_is_any_ring: assert property (@(posedge clk) disable iff (rst)
    backpressure == (|ring_below));

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
    a_r7_only_active_rings: assert property (@(posedge clk) disable iff (rst)
      ring_below[i] |-> $past(act_w[i]));

    a_r6_below_is_strict: assert property (@(posedge clk) disable iff (rst)
      ring_below[i] |-> (ring_free[i*CNT_W +: CNT_W] < $past(thr_w_flat[i*CNT_W +: CNT_W])));

    a_r6_short_ring_flagged: assert property (@(posedge clk) disable iff (rst)
      ($past(rx_en) && $past(act_w[i]) &&
       ring_free[i*CNT_W +: CNT_W] < $past(thr_w_flat[i*CNT_W +: CNT_W])) |-> ring_below[i]);
  end
endmodule

bind rx_freebd_monitor rxbp_checker #(.NUM_RINGS(NUM_RINGS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .backpressure(backpressure),
  .ring_below(ring_below), .ring_free(ring_free),
  .thr_w_flat(thr_w_flat), .act_w(act_w)
);

// File: tb/rx_freebd_monitor_test.sv
module rx_freebd_monitor_test;
  localparam int N     = 4;
  localparam int CNT_W = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_en = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_ring = '0;
  logic [1:0]    cfg_field = '0;
  logic [31:0]   cfg_data = '0;
  logic          free_we = 1'b0;
  logic [1:0]    free_ring = '0;
  logic [31:0]   free_addr = '0;
  logic [N-1:0]  wb_strobe = '0;
  logic          backpressure;
  logic [N-1:0]  ring_below;
  logic [N*CNT_W-1:0] ring_free;

  rx_freebd_monitor uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .cfg_we(cfg_we), .cfg_ring(cfg_ring),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .free_we(free_we),
    .free_ring(free_ring), .free_addr(free_addr), .wb_strobe(wb_strobe),
    .backpressure(backpressure), .ring_below(ring_below), .ring_free(ring_free)
  );

  always #4 clk = ~clk;

  typedef struct {
    string              tag;
    logic               bp;
    logic [N-1:0]       below;
    logic [N*CNT_W-1:0] free;
  } exp_t;

  exp_t sb[$];
  event sample_ev;
  int   vectors = 0;
  int   errors  = 0;

  // reference model
  logic [31:0] m_base [N];
  int m_len_p[N], m_thr_p[N], m_act_p[N];
  int m_len[N], m_thr[N], m_act[N];
  int m_hw[N], m_fr[N], m_empty[N];
  bit m_en = 0;

  function automatic int m_free(int i);
    if (m_empty[i] != 0) return m_len[i];
    if (m_fr[i] >= m_hw[i]) return m_fr[i] - m_hw[i];
    return m_fr[i] + m_len[i] - m_hw[i];
  endfunction

  task automatic settle(string tag);
    exp_t e;
    if (!m_en) begin
      for (int i = 0; i < N; i++) begin
        m_len[i] = m_len_p[i]; m_thr[i] = m_thr_p[i]; m_act[i] = m_act_p[i];
      end
    end
    e.tag = tag; e.below = '0; e.free = '0;
    for (int i = 0; i < N; i++) begin
      e.free[i*CNT_W +: CNT_W] = CNT_W'(m_free(i));
      e.below[i] = m_en && (m_act[i] != 0) && (m_free(i) < m_thr[i]);
    end
    e.bp = |e.below;
    sb.push_back(e);
    repeat (2) @(posedge clk);
    #1 -> sample_ev;
  endtask

  task automatic cfg(int r, int f, logic [31:0] d, string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ring = 2'(r); cfg_field = 2'(f); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (f)
      0: begin m_base[r] = d; m_hw[r] = 0; m_fr[r] = 0; m_empty[r] = 1; end
      1: m_len_p[r] = int'(d[CNT_W-1:0]);
      2: m_thr_p[r] = int'(d[CNT_W-1:0]);
      default: m_act_p[r] = int'(d[0]);
    endcase
    settle(tag);
  endtask

  task automatic set_en(bit v, string tag);
    @(negedge clk);
    rx_en = v;
    @(negedge clk);
    m_en = v;
    settle(tag);
  endtask

  task automatic wb(int r, int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wb_strobe[r] = 1'b1;
      @(negedge clk);
      wb_strobe[r] = 1'b0;
      if (m_en) begin
        m_hw[r] = (m_hw[r] + 1 >= m_len[r]) ? 0 : m_hw[r] + 1;
        m_empty[r] = 0;
      end
    end
    settle(tag);
  endtask

  task automatic freed(int r, logic [31:0] a, string tag);
    logic [31:0] off;
    @(negedge clk);
    free_we = 1'b1; free_ring = 2'(r); free_addr = a;
    @(negedge clk);
    free_we = 1'b0;
    off = a - m_base[r];
    if ((off >> 3) < 32'(m_len[r])) begin
      m_fr[r] = int'(off >> 3); m_empty[r] = 0;
    end
    settle(tag);
  endtask

  // monitor: pops expected items and compares
  initial begin
    forever begin
      exp_t e;
      @(sample_ev);
      e = sb.pop_front();
      vectors++;
      if (backpressure !== e.bp) begin
        errors++;
        $display("FAIL %s backpressure actual=%0b expected=%0b", e.tag, backpressure, e.bp);
      end
      vectors++;
      if (ring_below !== e.below) begin
        errors++;
        $display("FAIL %s ring_below actual=%b expected=%b", e.tag, ring_below, e.below);
      end
      for (int i = 0; i < N; i++) begin
        vectors++;
        if (ring_free[i*CNT_W +: CNT_W] !== e.free[i*CNT_W +: CNT_W]) begin
          errors++;
          $display("FAIL %s ring_free[%0d] actual=%0d expected=%0d", e.tag, i,
                   ring_free[i*CNT_W +: CNT_W], e.free[i*CNT_W +: CNT_W]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_base[i] = '0; m_len_p[i] = 0; m_thr_p[i] = 0; m_act_p[i] = 0;
      m_len[i] = 0; m_thr[i] = 0; m_act[i] = 0;
      m_hw[i] = 0; m_fr[i] = 0; m_empty[i] = 1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    settle("R1");

    cfg(0, 1, 32'd8,  "R10"); cfg(0, 2, 32'd3, "R10"); cfg(0, 3, 32'd1, "R10");
    cfg(0, 0, 32'h1000, "R2");
    cfg(1, 1, 32'd16, "R10"); cfg(1, 2, 32'd4, "R10"); cfg(1, 3, 32'd1, "R10");
    cfg(1, 0, 32'h2000, "R2");
    cfg(2, 1, 32'd4,  "R10"); cfg(2, 2, 32'd1, "R10"); cfg(2, 3, 32'd0, "R10");
    cfg(2, 0, 32'h3000, "R2");
    cfg(3, 1, 32'd64, "R10"); cfg(3, 2, 32'd2, "R10"); cfg(3, 3, 32'd1, "R10");
    cfg(3, 0, 32'h4000, "R2");

    set_en(1'b1, "R9");
    wb(0, 1, "R3");                      // free 7
    wb(0, 5, "R6");                      // hw 6, free 2 < 3
    freed(0, 32'h1000 + 7*8, "R4");      // free 1
    freed(0, 32'h1000 + 1*8, "R6");      // free 3 == thr, not below
    freed(0, 32'h1000 + 2*8, "R4");      // wrap distance, free 4
    freed(0, 32'h1000 + 8*8, "R4");      // index == length, ignored
    freed(0, 32'h0FF8, "R4");            // below base, ignored
    wb(2, 4, "R7");                      // inactive ring wraps to 0 free
    wb(2, 0, "R5");
    wb(0, 2, "R3");                      // hw wraps 7 -> 0, free 2
    wb(1, 13, "R8");                     // ring1 free 3 < 4, two rings below
    freed(0, 32'h1000 + 5*8, "R8");      // ring0 recovers, ring1 still below
    freed(1, 32'h2000, "R8");            // ring1 free 3
    freed(1, 32'h2000 + 1*8, "R8");      // ring1 free 4, request drops
    freed(0, 32'h1000, "R5");            // freed == consume, free 0
    set_en(1'b0, "R9");
    wb(0, 1, "R9");                      // ignored while disabled
    set_en(1'b1, "R10");
    cfg(0, 2, 32'd0, "R10");             // threshold write while running: no effect
    set_en(1'b0, "R10");
    set_en(1'b1, "R10");                 // new threshold 0 now in force
    cfg(0, 0, 32'h1800, "R2");           // base rewrite while running
    freed(0, 32'h1800 + 3*8, "R4");      // free 3

    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule